// File: doc/BRIEF.md
# USB Host Interrupt Status Controller

This block holds the interrupt status and interrupt enable state of a full-speed/low-speed USB host controller. The frame timer, root hub, schedule engine, done-queue writeback engine and system-bus error logic each report events as single-cycle strobes or levels. The block turns each event into a sticky status bit, masks the status word with per-source enables and a master enable, and drives one registered interrupt line toward the processor.

Some sources need more than a plain latch. The frame-overflow source watches the top bit of the frame number whenever the frame number copy is refreshed. The resume source reacts only to the start of downstream resume signalling, and ignores it while software itself drives the resume state. The done-head source also controls its own request/grant handshake, so a second writeback cannot be granted while the first is unacknowledged. Schedule overruns also advance a small wrapping counter. A pending system-error bit raises a halt output that stops the rest of the controller.

Software reaches the block through a one-cycle register port with four word addresses. Reads are combinational, and writes take effect at the next clock edge.

Top module: `usb_hc_irq_ctrl`

## Requirements
- R1: Status word (address 0) bit layout: 0 frame start, 1 frame-number overflow, 2 schedule overrun, 3 done-head written, 4 resume detected, 5 root-hub change, 6 system error; upper bits read 0. Each bit is set by its event at the next clock edge and stays set until software clears it.
- R2: A write to address 0 clears every status bit whose data bit is 1. Data bits of 0 leave their status bits unchanged. A set event in the same cycle as a clear of that bit leaves the bit set.
- R3: When `frame_upd` is high and bit FN_W-1 of `frame_num` differs from the value recorded at the previous update, the overflow bit is set. This applies in both directions. The recorded value is 0 after reset.
- R4: Every cycle with `frame_upd` high sets the frame-start bit.
- R5: The resume bit is set only in a cycle where `resume_sig` is high, it was low in the previous cycle, and `sw_resume` is low. A held level, or a rising edge while `sw_resume` is high, does not set it.
- R6: Each `sched_ovr` strobe sets the overrun bit and increments a 2-bit counter modulo 4. The counter reads at bits 17:16 of address 3, and the other bits of that word read 0.
- R7: A write to address 1 sets, and a write to address 2 clears, each enable whose data bit is 1. Bits 6:0 are the per-source enables in the status layout, and bit 31 is the master enable. A read of either address returns the enable word.
- R8: `irq` is registered. It equals, one cycle later, the master enable ANDed with the OR of (status AND enables). With the master enable low it stays low.
- R9: `wb_gnt` is `wb_req` while both the done-head bit and the system-error bit are clear, and 0 otherwise.
- R10: `hc_halt` is high exactly while the system-error status bit is set.
- R11: A `rh_change` strobe sets the root-hub change bit.
- R12: After reset, the status word, enable word, overrun counter, `irq` and `hc_halt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_upd | input | 1 | Frame number copy updated, new frame started |
| frame_num | input | FN_W | Frame number just written |
| sched_ovr | input | 1 | Current frame's schedule overran |
| wb_req | input | 1 | Done-head writeback request |
| wb_gnt | output | 1 | Done-head writeback grant |
| wb_done | input | 1 | Done-head written to shared memory |
| resume_sig | input | 1 | Downstream resume signalling level |
| sw_resume | input | 1 | Software-driven resume state active |
| rh_change | input | 1 | Root hub or port status changed |
| sys_err | input | 1 | Non-USB system error |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| irq | output | 1 | Registered interrupt request |
| hc_halt | output | 1 | Stop processing, system error pending |

## Verification
The bench uses the default parameters: a 16-bit frame number, a 32-bit register word and a 2-bit overrun counter. The narrow counter means only four overruns are needed to reach the wrap. Both directions of the frame-number top-bit toggle are driven directly. The random phase feeds frame numbers whose top bit changes often, together with level-style resume and software-resume inputs. This exercises edge detection against held levels, and collisions between set events and clears.

// File: rtl/usb_irq_pkg.sv
// Shared constants for the USB host interrupt status controller.
// Assumes a fixed set of seven interrupt sources; the bit indices below
// define the status and enable word layout seen by software.
package usb_irq_pkg;
    localparam int NSRC    = 7;
    localparam int SRC_SOF = 0;
    localparam int SRC_FNO = 1;
    localparam int SRC_OVR = 2;
    localparam int SRC_WDH = 3;
    localparam int SRC_RES = 4;
    localparam int SRC_RHC = 5;
    localparam int SRC_UE  = 6;

    typedef enum logic [1:0] {
        A_STATUS = 2'd0,
        A_EN_SET = 2'd1,
        A_EN_CLR = 2'd2,
        A_CMD    = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq_event_detect.sv
// Turns raw event inputs into one set-pulse per status source.
// Tracks the frame-number top bit across updates and the previous resume
// level. Assumes strobes are one cycle wide and synchronous to clk.
module irq_event_detect
    import usb_irq_pkg::*;
#(
    parameter int FN_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_upd,
    input  logic [FN_W-1:0] frame_num,
    input  logic            sched_ovr,
    input  logic            wb_done,
    input  logic            resume_sig,
    input  logic            sw_resume,
    input  logic            rh_change,
    input  logic            sys_err,
    output logic [NSRC-1:0] evt
);
    localparam int MSB = FN_W - 1;

    logic msb_q;
    logic res_q;
    logic unused_fn;

    assign unused_fn = ^frame_num[MSB-1:0];

    // Record the frame-number top bit at each frame number update.
    always_ff @(posedge clk) begin
        if (!rst_n)         msb_q <= 1'b0;
        else if (frame_upd) msb_q <= frame_num[MSB];
    end

    // Keep last cycle's resume level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= 1'b0;
        else        res_q <= resume_sig;
    end

    // Build the per-source set vector.
    always_comb begin
        evt          = '0;
        evt[SRC_SOF] = frame_upd;
        evt[SRC_FNO] = frame_upd & (frame_num[MSB] ^ msb_q);
        evt[SRC_OVR] = sched_ovr;
        evt[SRC_WDH] = wb_done;
        evt[SRC_RES] = resume_sig & ~res_q & ~sw_resume;
        evt[SRC_RHC] = rh_change;
        evt[SRC_UE]  = sys_err;
    end

    assert_no_sw_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sw_resume |-> !evt[SRC_RES]);

    assert_fno_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt[SRC_FNO] |=> (msb_q != $past(msb_q)));
endmodule

// File: rtl/irq_sticky_bank.sv
// Sticky status bits, one per source; set dominates write-one-to-clear.
// Assumes set and clear vectors are valid for one cycle each.
module irq_sticky_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] st
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One status flop: clear on request, but a same-cycle set wins.
        always_ff @(posedge clk) begin
            if (!rst_n)          st[i] <= 1'b0;
            else if (set_vec[i]) st[i] <= 1'b1;
            else if (clr_vec[i]) st[i] <= 1'b0;
        end

        assert_sticky_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (st[i] && !clr_vec[i]) |=> st[i]);

        assert_set_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> st[i]);
    end
endmodule

// File: rtl/irq_enable_bank.sv
// Per-source enables, master enable and the registered interrupt output.
// Assumes set and clear writes never occur in the same cycle.
module irq_enable_bank #(
    parameter int N       = 7,
    parameter int DATA_W  = 32,
    parameter int MIE_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N-1:0]      status,
    output logic [N-1:0]      en_q,
    output logic              mie_q,
    output logic              irq
);
    // Set or clear the source enables on their write addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (wr_set) en_q <= en_q | wdata[N-1:0];
        else if (wr_clr) en_q <= en_q & ~wdata[N-1:0];
    end

    // Set or clear the master enable on the same addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)                          mie_q <= 1'b0;
        else if (wr_set && wdata[MIE_BIT])   mie_q <= 1'b1;
        else if (wr_clr && wdata[MIE_BIT])   mie_q <= 1'b0;
    end

    // Register the masked OR so the line is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= mie_q & (|(status & en_q));
    end

    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mie_q |=> !irq);
endmodule

// File: rtl/usb_hc_irq_ctrl.sv
// Top of the USB host interrupt status controller: register decode,
// schedule-overrun counter, writeback grant gating and halt output.
// Assumes a one-cycle write strobe and combinational reads.
module usb_hc_irq_ctrl
    import usb_irq_pkg::*;
#(
    parameter int FN_W        = 16,
    parameter int DATA_W      = 32,
    parameter int MIE_BIT     = 31,
    parameter int OVR_CNT_W   = 2,
    parameter int OVR_CNT_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_upd,
    input  logic [FN_W-1:0]   frame_num,
    input  logic              sched_ovr,
    input  logic              wb_req,
    output logic              wb_gnt,
    input  logic              wb_done,
    input  logic              resume_sig,
    input  logic              sw_resume,
    input  logic              rh_change,
    input  logic              sys_err,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              hc_halt
);
    localparam int PAD_W = DATA_W - NSRC;

    logic [NSRC-1:0]      evt;
    logic [NSRC-1:0]      st;
    logic [NSRC-1:0]      clr_vec;
    logic [NSRC-1:0]      en_q;
    logic                 mie_q;
    logic [OVR_CNT_W-1:0] ovr_cnt;
    logic                 wr_set;
    logic                 wr_clr;
    logic                 unused_wdata;

    assign unused_wdata = ^reg_wdata;

    irq_event_detect #(.FN_W(FN_W)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_upd  (frame_upd),
        .frame_num  (frame_num),
        .sched_ovr  (sched_ovr),
        .wb_done    (wb_done),
        .resume_sig (resume_sig),
        .sw_resume  (sw_resume),
        .rh_change  (rh_change),
        .sys_err    (sys_err),
        .evt        (evt)
    );

    // Decode the write strobes for the status and enable addresses.
    always_comb begin
        clr_vec = '0;
        wr_set  = 1'b0;
        wr_clr  = 1'b0;
        if (reg_wr) begin
            case (reg_addr_e'(reg_addr))
                A_STATUS: clr_vec = reg_wdata[NSRC-1:0];
                A_EN_SET: wr_set  = 1'b1;
                A_EN_CLR: wr_clr  = 1'b1;
                default:  ;
            endcase
        end
    end

    irq_sticky_bank #(.N(NSRC)) u_st (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (evt),
        .clr_vec (clr_vec),
        .st      (st)
    );

    irq_enable_bank #(.N(NSRC), .DATA_W(DATA_W), .MIE_BIT(MIE_BIT)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_set (wr_set),
        .wr_clr (wr_clr),
        .wdata  (reg_wdata),
        .status (st),
        .en_q   (en_q),
        .mie_q  (mie_q),
        .irq    (irq)
    );

    // Count schedule overruns, wrapping at the counter width.
    always_ff @(posedge clk) begin
        if (!rst_n)         ovr_cnt <= '0;
        else if (sched_ovr) ovr_cnt <= ovr_cnt + 1'b1;
    end

    // Combinational read mux over the four word addresses.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr_e'(reg_addr))
            A_STATUS: reg_rdata = {{PAD_W{1'b0}}, st};
            A_EN_SET,
            A_EN_CLR: begin
                reg_rdata[NSRC-1:0] = en_q;
                reg_rdata[MIE_BIT]  = mie_q;
            end
            A_CMD:    reg_rdata[OVR_CNT_LSB +: OVR_CNT_W] = ovr_cnt;
            default:  reg_rdata = '0;
        endcase
    end

    assign wb_gnt  = wb_req & ~st[SRC_WDH] & ~st[SRC_UE];
    assign hc_halt = st[SRC_UE];

    assert_ovr_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sched_ovr |=> (OVR_CNT_W'(ovr_cnt - $past(ovr_cnt)) == OVR_CNT_W'(1)));

    assert_wb_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_done |=> !wb_gnt);

    assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_err && !$isunknown(sys_err)) |=> hc_halt);
endmodule

// File: tb/tb_usb_hc_irq_ctrl.sv
`timescale 1ns/100ps
module tb_usb_hc_irq_ctrl;
    localparam int FN_W = 16;
    localparam int DW   = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frame_upd = 0, sched_ovr = 0, wb_req = 0, wb_done = 0;
    logic            resume_sig = 0, sw_resume = 0, rh_change = 0, sys_err = 0;
    logic            reg_wr = 0;
    logic [1:0]      reg_addr = 0;
    logic [FN_W-1:0] frame_num = 0;
    logic [DW-1:0]   reg_wdata = 0;
    logic [DW-1:0]   reg_rdata;
    logic            wb_gnt, irq, hc_halt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model state
    logic [6:0] m_st = 0;
    logic [6:0] m_en = 0;
    logic       m_mie = 0, m_msb = 0, m_resq = 0, m_irq = 0;
    logic [1:0] m_cnt = 0;

    always #2 clk = ~clk;

    usb_hc_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .frame_upd(frame_upd), .frame_num(frame_num),
        .sched_ovr(sched_ovr), .wb_req(wb_req), .wb_gnt(wb_gnt), .wb_done(wb_done),
        .resume_sig(resume_sig), .sw_resume(sw_resume), .rh_change(rh_change),
        .sys_err(sys_err), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .hc_halt(hc_halt)
    );

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] m_read(logic [1:0] a);
        logic [DW-1:0] r = '0;
        case (a)
            2'd0: r[6:0] = m_st;
            2'd1, 2'd2: begin r[6:0] = m_en; r[31] = m_mie; end
            default: r[17:16] = m_cnt;
        endcase
        return r;
    endfunction

    function automatic string rd_tag(logic [1:0] a);
        if (a == 2'd0) return "R1";
        if (a == 2'd3) return "R6";
        return "R7";
    endfunction

    // One clock: check comb outputs, predict, clock, update model, check irq.
    task automatic step();
        logic [6:0] evt, clr, n_st, n_en;
        logic       n_mie, n_irq;
        #0.5;
        chk(rd_tag(reg_addr), reg_rdata, m_read(reg_addr));
        chk("R9", {31'b0, wb_gnt}, {31'b0, wb_req & ~m_st[3] & ~m_st[6]});
        chk("R10", {31'b0, hc_halt}, {31'b0, m_st[6]});
        evt    = '0;
        evt[0] = frame_upd;
        evt[1] = frame_upd & (frame_num[15] ^ m_msb);
        evt[2] = sched_ovr;
        evt[3] = wb_done;
        evt[4] = resume_sig & ~m_resq & ~sw_resume;
        evt[5] = rh_change;
        evt[6] = sys_err;
        clr    = (reg_wr && reg_addr == 2'd0) ? reg_wdata[6:0] : 7'd0;
        n_st   = (m_st & ~clr) | evt;
        n_en   = m_en;
        n_mie  = m_mie;
        if (reg_wr && reg_addr == 2'd1) begin n_en = m_en | reg_wdata[6:0]; n_mie = m_mie | reg_wdata[31]; end
        if (reg_wr && reg_addr == 2'd2) begin n_en = m_en & ~reg_wdata[6:0]; n_mie = m_mie & ~reg_wdata[31]; end
        n_irq  = m_mie & |(m_st & m_en);
        @(posedge clk);
        #0.5;
        if (frame_upd) m_msb = frame_num[15];
        m_resq = resume_sig;
        if (sched_ovr) m_cnt = m_cnt + 2'd1;
        m_st = n_st; m_en = n_en; m_mie = n_mie; m_irq = n_irq;
        chk("R8", {31'b0, irq}, {31'b0, m_irq});
        @(negedge clk);
    endtask

    task automatic idle();
        frame_upd = 0; sched_ovr = 0; wb_done = 0; rh_change = 0; sys_err = 0;
        reg_wr = 0; reg_wdata = 0; wb_req = 0;
    endtask

    task automatic rd_chk(string tag, logic [1:0] a, logic [DW-1:0] mask, logic [DW-1:0] exp);
        reg_wr = 0; reg_addr = a; #0.5;
        chk(tag, reg_rdata & mask, exp);
    endtask

    task automatic wr(logic [1:0] a, logic [DW-1:0] d);
        idle(); reg_wr = 1; reg_addr = a; reg_wdata = d; step(); idle();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed = 20240611;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R12: reset state
        rd_chk("R12", 2'd0, '1, 0);
        rd_chk("R12", 2'd1, '1, 0);
        rd_chk("R12", 2'd3, '1, 0);
        chk("R12", {31'b0, irq}, 0);
        chk("R12", {31'b0, hc_halt}, 0);

        // R4 / R3: frame start and top-bit toggle both ways
        frame_upd = 1; frame_num = 16'h7FFF; step(); idle();
        rd_chk("R4", 2'd0, 32'h3, 32'h1);
        wr(2'd0, 32'h7F);
        frame_upd = 1; frame_num = 16'h8000; step(); idle();
        rd_chk("R3", 2'd0, 32'h2, 32'h2);
        wr(2'd0, 32'h7F);
        frame_upd = 1; frame_num = 16'h8001; step(); idle();
        rd_chk("R3", 2'd0, 32'h2, 32'h0);
        frame_upd = 1; frame_num = 16'h0000; step(); idle();
        rd_chk("R3", 2'd0, 32'h2, 32'h2);
        wr(2'd0, 32'h7F);

        // R11 / R2: set vs clear collision, zero write ignored
        rh_change = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 32'h20; step(); idle();
        rd_chk("R2", 2'd0, 32'h20, 32'h20);
        rd_chk("R11", 2'd0, '1, 32'h20);
        wr(2'd0, 32'h0);
        rd_chk("R2", 2'd0, 32'h20, 32'h20);
        wr(2'd0, 32'h20);
        rd_chk("R2", 2'd0, '1, 32'h0);

        // R5: resume edge rules
        sw_resume = 1; resume_sig = 1; step();
        sw_resume = 0; step(); step();
        rd_chk("R5", 2'd0, 32'h10, 32'h0);
        resume_sig = 0; step();
        resume_sig = 1; step();
        rd_chk("R5", 2'd0, 32'h10, 32'h10);
        resume_sig = 0;
        wr(2'd0, 32'h7F);

        // R6: overrun counter wrap
        for (int i = 0; i < 3; i++) begin sched_ovr = 1; step(); idle(); end
        rd_chk("R6", 2'd3, '1, 32'h0003_0000);
        rd_chk("R6", 2'd0, 32'h4, 32'h4);
        sched_ovr = 1; step(); idle();
        rd_chk("R6", 2'd3, '1, 32'h0);
        wr(2'd0, 32'h7F);

        // R9 / R10: writeback gating and halt
        wb_done = 1; step(); idle();
        wb_req = 1; #0.5; chk("R9", {31'b0, wb_gnt}, 0);
        wr(2'd0, 32'h08);
        wb_req = 1; #0.5; chk("R9", {31'b0, wb_gnt}, 1);
        idle(); sys_err = 1; step(); idle();
        wb_req = 1; #0.5; chk("R10", {30'b0, hc_halt, wb_gnt}, 32'h2);
        wr(2'd0, 32'h40);

        // R8 / R7: master enable gating and registered irq
        wr(2'd1, 32'h20);
        rh_change = 1; step(); idle(); step();
        chk("R8", {31'b0, irq}, 0);
        wr(2'd1, 32'h8000_0000);
        rd_chk("R7", 2'd2, '1, 32'h8000_0020);
        step();
        chk("R8", {31'b0, irq}, 1);
        wr(2'd2, 32'h20);
        rd_chk("R7", 2'd1, '1, 32'h8000_0000);
        wr(2'd0, 32'h7F);

        // Constrained random phase
        for (int c = 0; c < 4000; c++) begin
            frame_upd  = ($urandom % 4) == 0;
            frame_num  = 16'($urandom);
            sched_ovr  = ($urandom % 8) == 0;
            wb_req     = $urandom % 2;
            wb_done    = ($urandom % 10) == 0;
            if (($urandom % 5) == 0) resume_sig = ~resume_sig;
            if (($urandom % 7) == 0) sw_resume = ~sw_resume;
            rh_change  = ($urandom % 9) == 0;
            sys_err    = ($urandom % 40) == 0;
            reg_wr     = ($urandom % 4) == 0;
            reg_addr   = 2'($urandom);
            reg_wdata  = $urandom;
            step();
        end
        idle();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule